// File: doc/BRIEF.md
# Rounding encoder from unrounded intermediate form to posit

This combinational block turns one arithmetic result, held in a fixed-width intermediate form, into the nearest N-bit posit word. The intermediate form has five fields. A not-a-real flag marks an invalid result. A sign bit `s` is followed by a two's complement exponent `e`. A weight bit `i` is one only for strictly positive values. A two's complement fraction `f` completes it, so a value is `(-2s + i + 0.f) * 2^e`. Two more bits carry the rest of the exact result. One is a round bit that sits just below the fraction LSB. The other is a sticky bit that is set when anything nonzero lies below the round bit.

The exponent is split into a high part `eh = e >>> WES` and a low part of `WES` bits. The high part sets the length of a run of identical bits, the regime. The regime, the low exponent bits, the fraction and the round bit are packed into one stem. The stem is shifted right by the regime length, so the number of fraction bits that survive depends on the exponent. Every bit that falls off the end is folded into a sticky bit. The kept word is then rounded to nearest, ties to even, by one increment.

The producer must saturate the value first. Magnitudes above the largest posit or below the smallest nonzero posit must not reach the encoder.

Top module: `posit_upif_encoder`

## Requirements
- R1: For `eh >= 0` the regime is `eh+1` copies of `~s` followed by one `s`. For `eh < 0` it is `-eh` copies of `s` followed by one `~s`. The regime sits directly below the sign bit, which is output bit N-1.
- R2: The `WES` bits below the regime terminator equal `e[WES-1:0] XOR s`.
- R3: Fraction bits follow the exponent bits MSB first. Those that do not fit in the N-bit word are dropped.
- R4: The first bit below the kept word, which may be the input round bit, decides rounding. An exact tie (that bit 1, nothing below it) rounds up only when the kept LSB is 1.
- R5: The sticky used for rounding is the OR of the input sticky bit and every bit shifted below the round position. Any nonzero sticky with the round position set rounds up.
- R6: With the not-a-real flag set, the output is the word with only bit N-1 set, whatever the other inputs are.
- R7: With `s = 0` and `i = 0`, the output is all zeros, whatever the round and sticky inputs are.
- R8: When the regime needs N-1 or more bits, the word is filled with regime bits. The terminator becomes the round position and all lower fields feed the sticky. Examples for N=16, WES=1: e=28 gives 7FFF, e=-28 (positive) gives 0001, and e=-29 with `s=1` and `f=0` gives FFFF.
- R9: For a nonzero, valid input, the output is never the not-a-real word or zero, and its bit N-1 equals `s`. A round-up whose kept magnitude is all ones is suppressed.
- R10: Decoding any N-bit posit into the intermediate form, then encoding it with round and sticky at zero, gives back the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| nar_i | input | 1 | not-a-real flag |
| sgn_i | input | 1 | sign bit `s` |
| exp_i | input | WE | two's complement exponent, WE = 1+WES+clog2(N-2) |
| one_i | input | 1 | weight bit `i`, one only for strictly positive values |
| frac_i | input | WF | fraction, WF = N-3-WES |
| rnd_i | input | 1 | round bit below the fraction LSB |
| stk_i | input | 1 | sticky bit below the round bit |
| posit_o | output | N | rounded posit word |

## Verification
The bench uses N=16 and WES=1. At this size the round trip can be run over all 65,536 patterns. That sweep covers every regime length from 1 to 15 for both signs, the full-regime words at both ends of the range, and the two special words. Random exponents over the whole unsaturated range move the rounding position across all fraction bits and the single exponent bit. Directed ties, sticky-only cases and saturated-regime cases pin down the even rule and the folding of dropped bits.

// File: rtl/posit_enc_pkg.sv
package posit_enc_pkg;

    // Width of the two's complement exponent of the intermediate form.
    function automatic int exp_width(input int n, input int wes);
        return 1 + wes + $clog2(n - 2);
    endfunction

    // Width of the two's complement fraction of the intermediate form.
    function automatic int frac_width(input int n, input int wes);
        return n - 3 - wes;
    endfunction

    // Bits needed to hold a right shift in 0 .. n-2.
    function automatic int shamt_width(input int n);
        return $clog2(n - 1);
    endfunction

endpackage

// File: rtl/posit_stem_build.sv
module posit_stem_build #(
    parameter int N   = 16,
    parameter int WES = 1,
    parameter int WE  = 6,
    parameter int WF  = 12,
    parameter int SAW = 4
) (
    input  logic [WE-1:0]  exp_i,
    input  logic           sgn_i,
    input  logic [WF-1:0]  frac_i,
    input  logic           rnd_i,
    output logic           fill_o,
    output logic [N-2:0]   stem_o,
    output logic [SAW-1:0] sa_o
);
    localparam logic [WE-1:0] SA_MAX = WE'(N - 2);

    logic signed [WE-1:0] hi_exp;
    logic                 hi_neg;
    logic [WE-1:0]        sa_full;
    logic [WE-1:0]        sa_clip;

    // Regime length minus one: eh for eh >= 0, -eh-1 (= ~eh) for eh < 0.
    always_comb begin
        hi_exp  = $signed(exp_i) >>> WES;
        hi_neg  = hi_exp[WE-1];
        sa_full = hi_neg ? ~hi_exp : hi_exp;
        sa_clip = (sa_full > SA_MAX) ? SA_MAX : sa_full;
        fill_o  = hi_neg ? sgn_i : ~sgn_i;
    end

    assign sa_o = SAW'(sa_clip);

    // Stem: terminator, sign-adjusted low exponent bits, fraction, round bit.
    generate
        if (WES > 0) begin : g_with_es
            assign stem_o = {~fill_o, exp_i[WES-1:0] ^ {WES{sgn_i}}, frac_i, rnd_i};
        end else begin : g_no_es
            assign stem_o = {~fill_o, frac_i, rnd_i};
        end
    endgenerate

endmodule

// File: rtl/posit_shift_sticky.sv
module posit_shift_sticky #(
    parameter int L   = 15,
    parameter int SAW = 4
) (
    input  logic           fill_i,
    input  logic [L-1:0]   stem_i,
    input  logic [SAW-1:0] sa_i,
    output logic [L-1:0]   kept_o,
    output logic           rnd_o,
    output logic           stk_o
);
    localparam int VW = 2 * L;

    logic [SAW:0][VW-1:0] vec;
    logic [SAW:0]         stk;

    assign vec[0] = {{L{fill_i}}, stem_i};
    assign stk[0] = 1'b0;

    // Binary-weighted stages; each folds the bits it drops into the sticky.
    generate
        for (genvar j = 0; j < SAW; j++) begin : g_stage
            localparam int SH = 1 << j;
            assign vec[j+1] = sa_i[j] ? (vec[j] >> SH) : vec[j];
            assign stk[j+1] = stk[j] | (sa_i[j] & (|vec[j][SH-1:0]));
        end
    endgenerate

    // The fixed final one-bit step exposes the round position.
    assign kept_o = vec[SAW][L:1];
    assign rnd_o  = vec[SAW][0];
    assign stk_o  = stk[SAW];

endmodule

// File: rtl/posit_round_inc.sv
module posit_round_inc #(
    parameter int N = 16
) (
    input  logic         sgn_i,
    input  logic [N-2:0] kept_i,
    input  logic         rnd_i,
    input  logic         stk_i,
    output logic [N-1:0] word_o
);
    logic bump;

    always_comb begin
        bump   = rnd_i & (stk_i | kept_i[0]) & ~(&kept_i);
        word_o = {sgn_i, kept_i + {{(N-2){1'b0}}, bump}};
    end

endmodule

// File: rtl/posit_upif_encoder.sv
module posit_upif_encoder
    import posit_enc_pkg::*;
#(
    parameter  int N   = 16,
    parameter  int WES = 1,
    localparam int WE  = exp_width(N, WES),
    localparam int WF  = frac_width(N, WES)
) (
    input  logic          nar_i,
    input  logic          sgn_i,
    input  logic [WE-1:0] exp_i,
    input  logic          one_i,
    input  logic [WF-1:0] frac_i,
    input  logic          rnd_i,
    input  logic          stk_i,
    output logic [N-1:0]  posit_o
);
    localparam int           SAW  = shamt_width(N);
    localparam logic [N-1:0] NAR_WORD = {1'b1, {(N-1){1'b0}}};

    logic           fill;
    logic [N-2:0]   stem;
    logic [SAW-1:0] sa;
    logic [N-2:0]   kept;
    logic           rnd_pos;
    logic           stk_shift;
    logic [N-1:0]   rounded;

    posit_stem_build #(.N(N), .WES(WES), .WE(WE), .WF(WF), .SAW(SAW)) u_stem (
        .exp_i  (exp_i),
        .sgn_i  (sgn_i),
        .frac_i (frac_i),
        .rnd_i  (rnd_i),
        .fill_o (fill),
        .stem_o (stem),
        .sa_o   (sa)
    );

    posit_shift_sticky #(.L(N-1), .SAW(SAW)) u_shift (
        .fill_i (fill),
        .stem_i (stem),
        .sa_i   (sa),
        .kept_o (kept),
        .rnd_o  (rnd_pos),
        .stk_o  (stk_shift)
    );

    posit_round_inc #(.N(N)) u_round (
        .sgn_i  (sgn_i),
        .kept_i (kept),
        .rnd_i  (rnd_pos),
        .stk_i  (stk_shift | stk_i),
        .word_o (rounded)
    );

    always_comb begin
        if (nar_i)
            posit_o = NAR_WORD;
        else if (!sgn_i && !one_i)
            posit_o = '0;
        else
            posit_o = rounded;
    end

endmodule

// File: rtl/posit_upif_encoder_chk.sv
module posit_upif_encoder_chk #(
    parameter int N  = 16,
    parameter int WE = 6,
    parameter int WF = 12
) (
    input logic          nar_i,
    input logic          sgn_i,
    input logic [WE-1:0] exp_i,
    input logic          one_i,
    input logic [WF-1:0] frac_i,
    input logic          rnd_i,
    input logic          stk_i,
    input logic [N-1:0]  posit_o
);
    localparam logic [N-1:0] NAR_WORD = {1'b1, {(N-1){1'b0}}};

    always_comb begin
        if (!$isunknown({nar_i, sgn_i, one_i, posit_o})) begin
            assert_nar_out_R6: assert (!nar_i || posit_o == NAR_WORD)
                else $error("not-a-real input did not give the not-a-real word");
            assert_zero_out_R7: assert (nar_i || sgn_i || one_i || posit_o == '0)
                else $error("zero input did not give zero");
            assert_no_wrap_R9: assert (nar_i || !(sgn_i || one_i)
                                       || (posit_o != NAR_WORD && posit_o != '0))
                else $error("valid nonzero input gave a special word");
            assert_sign_kept_R9: assert (nar_i || !(sgn_i || one_i) || posit_o[N-1] == sgn_i)
                else $error("sign bit of result differs from input sign");
        end
    end

endmodule

bind posit_upif_encoder posit_upif_encoder_chk #(.N(N), .WE(WE), .WF(WF)) chk_i (.*);

// File: tb/posit_upif_encoder_tb_top.sv
module posit_upif_encoder_tb_top;
    import posit_enc_pkg::*;

    localparam int N    = 16;
    localparam int WES  = 1;
    localparam int WE   = exp_width(N, WES);
    localparam int WF   = frac_width(N, WES);
    localparam int EMAX = (N - 2) << WES;
    localparam logic [N-1:0] NAR_WORD = {1'b1, {(N-1){1'b0}}};

    logic          clk = 1'b0;
    logic          nar_i, sgn_i, one_i, rnd_i, stk_i;
    logic [WE-1:0] exp_i;
    logic [WF-1:0] frac_i;
    logic [N-1:0]  posit_o;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    always #5 clk = ~clk;

    posit_upif_encoder #(.N(N), .WES(WES)) dut_i (
        .nar_i(nar_i), .sgn_i(sgn_i), .exp_i(exp_i), .one_i(one_i),
        .frac_i(frac_i), .rnd_i(rnd_i), .stk_i(stk_i), .posit_o(posit_o)
    );

    // Bit-string model: lay out sign, regime, exponent, fraction, round; cut at N.
    function automatic logic [N-1:0] model_enc(bit n, bit s, bit i, int e,
                                               logic [WF-1:0] f, bit r, bit st);
        logic [63:0]  str;
        logic [N-2:0] kept;
        int p, eh, el, run;
        bit fb, rb, sb, up;
        if (n) return NAR_WORD;
        if (!s && !i) return '0;
        str = '0;
        p   = 63;
        eh  = e >>> WES;
        el  = e - (eh << WES);
        if (eh >= 0) begin run = eh + 1; fb = !s; end
        else         begin run = -eh;    fb = s;  end
        str[p] = s; p--;
        for (int j = 0; j < run; j++) begin str[p] = fb; p--; end
        str[p] = !fb; p--;
        for (int j = WES - 1; j >= 0; j--) begin str[p] = el[j] ^ s; p--; end
        for (int j = WF - 1; j >= 0; j--) begin str[p] = f[j]; p--; end
        str[p] = r;
        kept = str[62 -: (N-1)];
        rb   = str[63-N];
        sb   = st | (|str[62-N:0]);
        up   = rb & (sb | kept[0]) & !(&kept);
        return {s, kept + {{(N-2){1'b0}}, up}};
    endfunction

    // Posit word to intermediate fields.
    task automatic decode(input logic [N-1:0] pw, output bit n, output bit s,
                          output bit i, output int e, output logic [WF-1:0] f);
        int idx, l, eh, el;
        bit b, bt;
        n = 0; s = pw[N-1]; i = !s; e = 0; f = '0;
        if (pw == NAR_WORD) begin n = 1; s = 1; i = 0; return; end
        if (pw == '0) begin s = 0; i = 0; return; end
        b = pw[N-2]; l = 0; idx = N - 2;
        while (idx >= 0 && pw[idx] == b) begin l++; idx--; end
        idx--;
        eh = (b == s) ? -l : l - 1;
        el = 0;
        for (int j = 0; j < WES; j++) begin
            bt = (idx >= 0) ? pw[idx] : 1'b0; idx--;
            el = (el << 1) | int'(bt ^ s);
        end
        for (int j = WF - 1; j >= 0; j--) begin
            f[j] = (idx >= 0) ? pw[idx] : 1'b0; idx--;
        end
        e = eh * (1 << WES) + el;
    endtask

    task automatic drive(bit n, bit s, bit i, int e, logic [WF-1:0] f, bit r, bit st);
        @(posedge clk);
        #1;
        nar_i = n; sgn_i = s; one_i = i; exp_i = e[WE-1:0];
        frac_i = f; rnd_i = r; stk_i = st;
        @(negedge clk);
    endtask

    task automatic check(string req, logic [N-1:0] expv);
        checks++;
        if (posit_o !== expv) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, posit_o, expv);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        bit n, s, i;
        int e;
        logic [WF-1:0] f;
        void'($urandom(32'd20240611));
        nar_i = 0; sgn_i = 0; one_i = 0; exp_i = '0; frac_i = '0; rnd_i = 0; stk_i = 0;

        // Initial all-zero input
        drive(0, 0, 0, 0, '0, 0, 0);        check("R7 initial zero", 16'h0000);
        // Regime, exponent and fraction placement
        drive(0, 0, 1, 0, '0, 0, 0);        check("R1 one", 16'h4000);
        drive(0, 0, 1, 5, 12'h400, 0, 0);   check("R2 forty", 16'h7500);
        drive(0, 1, 0, -1, '0, 0, 0);       check("R1 minus one", 16'hC000);
        drive(0, 0, 1, 20, 12'h400, 0, 0);  check("R3 truncated fraction", 16'h7FF1);
        // Round bit and ties
        drive(0, 0, 1, 0, '0, 1, 0);        check("R4 tie even kept", 16'h4000);
        drive(0, 0, 1, 0, 12'h001, 1, 0);   check("R4 tie odd up", 16'h4002);
        drive(0, 0, 1, 20, 12'h600, 0, 0);  check("R4 shifted tie odd", 16'h7FF2);
        drive(0, 0, 1, 20, 12'h200, 0, 0);  check("R4 shifted tie even", 16'h7FF0);
        // Sticky sources
        drive(0, 0, 1, 0, '0, 1, 1);        check("R5 input sticky", 16'h4001);
        drive(0, 0, 1, 20, 12'h201, 0, 0);  check("R5 shifted sticky", 16'h7FF1);
        // Full regime
        drive(0, 0, 1, EMAX, '0, 0, 0);     check("R8 largest", 16'h7FFF);
        drive(0, 0, 1, -EMAX, '0, 0, 0);    check("R8 smallest", 16'h0001);
        drive(0, 1, 0, -EMAX-1, '0, 0, 0);  check("R8 negative smallest", 16'hFFFF);
        drive(0, 1, 0, -EMAX-1, '0, 1, 1);  check("R9 no wrap negative", 16'hFFFF);
        drive(0, 0, 1, EMAX, 12'hFFF, 1, 1); check("R9 no wrap positive", 16'h7FFF);
        // Specials ignore other fields
        drive(1, 0, 1, 7, 12'hABC, 1, 1);   check("R6 not-a-real", NAR_WORD);
        drive(0, 0, 0, 9, 12'h555, 1, 1);   check("R7 zero with round bits", 16'h0000);

        // Exhaustive round trip
        for (int w = 0; w < (1 << N); w++) begin
            decode(w[N-1:0], n, s, i, e, f);
            drive(n, s, i, e, f, 0, 0);
            check("R10 round trip", w[N-1:0]);
        end

        // Random rounding across the unsaturated range
        for (int k = 0; k < 4000; k++) begin
            bit rs, rr, rt;
            int re;
            logic [WF-1:0] rf;
            rs = bit'($urandom % 2);
            re = int'($urandom % (2 * EMAX)) - EMAX;
            rf = WF'($urandom);
            rr = bit'($urandom % 2);
            rt = bit'($urandom % 2);
            if (k % 8 == 0) rt = 0;
            drive(0, rs, !rs, re, rf, rr, rt);
            check("R4 R5 R1 random", model_enc(0, rs, !rs, re, rf, rr, rt));
        end

        done = 1;
        summary();
        $finish;
    end

endmodule